// File: doc/BRIEF.md
# Manual Power-On Debounce Detector

This block watches a slow, switch-driven input that arrives with no relation to the chip clock. It decides when the input carries a deliberate manual power-on press. The input is first synchronised and then sampled only on a 1 ms tick. Every later decision counts tick samples, so switch bounce and short spikes in either direction never reach the outputs.

A press that qualifies gives one of three results, depending on what the rest of the system is doing.
- While the interval configuration is still being read, the press aborts that read. The abort holds until the press has been released.
- While the gated power is already on (gate output low), the press is ignored.
- Otherwise the block emits a single-cycle power-on request and raises a held level. When the debounced release is recognised, it emits a release pulse that lets the interval counters restart.

The control is one state machine with four states:
- `ST_IDLE`: no press in progress.
- `ST_OBSERVE`: an observation window is open after the first high sample.
- `ST_HELD`: the press is accepted and the input is high.
- `ST_RELEASING`: a run of low samples is being counted.

The transitions are:
- start: `ST_IDLE`→`ST_OBSERVE`, on a high sample.
- qualify: `ST_OBSERVE`→`ST_HELD`, when enough high samples have been counted.
- reject: `ST_OBSERVE`→`ST_IDLE`, when the window ends short of that count.
- dip: `ST_HELD`→`ST_RELEASING`, on a low sample.
- bounce: `ST_RELEASING`→`ST_HELD`, on a high sample during the low run.
- release: `ST_RELEASING`→`ST_IDLE`, when the low run is complete.

Top module: `manual_wake_detector`

## Requirements
- R1: While reset is held and directly after it, `wake_pulse`, `release_pulse`, `held_active` and `cfg_abort` are all 0.
- R2: `btn_raw` passes through a two-stage synchroniser and is used only as sampled on a clock edge where `tick_ms` is 1. A high level that comes and goes between two ticks has no effect on any output, and the state changes only on tick edges.
- R3: A press opens a window at its first high sample, which counts as sample 1 of the window. It qualifies at the sample where the count of high samples in the window reaches HIGH_MS (default 20), provided this happens within WINDOW_MS samples (default 30). For a press that is neither ignored nor in configuration, `wake_pulse` is 1 for exactly the one clock cycle after that tick edge.
- R4: If the window's WINDOW_MS-th sample passes with fewer than HIGH_MS high samples, the press is rejected. No output is raised and the next high sample opens a new window.
- R5: `held_active` rises together with `wake_pulse` and stays 1 until the release. A run of low samples shorter than LOW_MS (default 20) that is followed by a high sample leaves it at 1.
- R6: After a qualified press, the LOW_MS-th consecutive low sample ends the press. For a press that produced a wake, `release_pulse` is 1 for the one clock cycle after that tick edge, and `held_active` falls in that same cycle.
- R7: `gate_n` = 0 means the gated power is already on. A press for which `gate_n` is 0 at the qualifying tick edge is ignored: no `wake_pulse`, no `held_active` and no `release_pulse` for that press.
- R8: A press whose first high sample is taken while `cfg_busy` is 1 raises `cfg_abort` from the cycle after that tick edge until the press ends by rejection or by release. Such a press produces no `wake_pulse`, `held_active` or `release_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| btn_raw | input | 1 | Raw manual power-on input, asynchronous |
| cfg_busy | input | 1 | 1 while the interval configuration read runs |
| gate_n | input | 1 | Current gate-output level, 0 = power on |
| wake_pulse | output | 1 | One-cycle power-on request |
| held_active | output | 1 | Accepted press still held |
| release_pulse | output | 1 | One-cycle pulse at recognised release, restarts counters |
| cfg_abort | output | 1 | Abort (and hold off) the configuration read |

## Verification
A wrong window or run counter shows up at the ports as a `wake_pulse` or `release_pulse` that moves by one or more ticks. A press that should fail could also qualify, and such a fault appears within one press, at most 30 ticks. A wrongly latched press class shows up at the qualifying tick as a wake that should have been suppressed, or as a missing `cfg_abort`. Every output is therefore compared after every tick against a tick-level model. The stimulus is directed around the exact thresholds, followed by seeded random press, bounce and release runs.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_OBSERVE   = 2'd1,
        ST_HELD      = 2'd2,
        ST_RELEASING = 2'd3
    } mwd_state_e;
endpackage

// File: rtl/mwd_sync.sv
module mwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mwd_fsm.sv
module mwd_fsm
    import mwd_pkg::*;
#(
    parameter int HIGH_MS   = 20,
    parameter int WINDOW_MS = 30,
    parameter int LOW_MS    = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sample,
    output logic ev_start,
    output logic ev_valid,
    output logic ev_release,
    output logic in_press,
    output logic latched
);
    localparam int HI_W  = $clog2(HIGH_MS + 1);
    localparam int WIN_W = $clog2(WINDOW_MS + 1);
    localparam int LO_W  = $clog2(LOW_MS + 1);

    mwd_state_e state_q, state_d;
    logic [HI_W-1:0]  hi_cnt_q;
    logic [WIN_W-1:0] win_cnt_q;
    logic [LO_W-1:0]  lo_cnt_q;
    logic [HI_W-1:0]  hi_next;
    logic [WIN_W-1:0] win_next;
    logic [LO_W-1:0]  lo_next;
    logic             ev_reject;

    assign hi_next  = hi_cnt_q + HI_W'(sample);
    assign win_next = win_cnt_q + WIN_W'(1);
    assign lo_next  = lo_cnt_q + LO_W'(1);

    always_comb begin
        ev_start   = tick && (state_q == ST_IDLE) && sample;
        ev_valid   = tick && (state_q == ST_OBSERVE) && (hi_next == HI_W'(HIGH_MS));
        ev_reject  = tick && (state_q == ST_OBSERVE) && !ev_valid
                     && (win_next == WIN_W'(WINDOW_MS));
        ev_release = tick && (state_q == ST_RELEASING) && !sample
                     && (lo_next == LO_W'(LOW_MS));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (ev_start) state_d = ST_OBSERVE;
            ST_OBSERVE:   if (ev_valid) state_d = ST_HELD;
                          else if (ev_reject) state_d = ST_IDLE;
            ST_HELD:      if (tick && !sample) state_d = ST_RELEASING;
            ST_RELEASING: if (tick && sample) state_d = ST_HELD;
                          else if (ev_release) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q  <= '0;
            win_cnt_q <= '0;
            lo_cnt_q  <= '0;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE: if (sample) begin
                    hi_cnt_q  <= HI_W'(1);
                    win_cnt_q <= WIN_W'(1);
                end
                ST_OBSERVE: begin
                    hi_cnt_q  <= hi_next;
                    win_cnt_q <= win_next;
                end
                ST_HELD: if (!sample) lo_cnt_q <= LO_W'(1);
                ST_RELEASING: lo_cnt_q <= sample ? '0 : lo_next;
                default: ;
            endcase
        end
    end

    always_comb begin
        in_press = (state_q != ST_IDLE);
        latched  = (state_q == ST_HELD) || (state_q == ST_RELEASING);
    end

    AST_HI_WITHIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OBSERVE) |-> (int'(hi_cnt_q) <= int'(win_cnt_q))); // R3
    AST_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_q)); // R2
endmodule

// File: rtl/mwd_class.sv
module mwd_class (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_start,
    input  logic ev_valid,
    input  logic ev_release,
    input  logic in_press,
    input  logic latched,
    input  logic cfg_busy,
    input  logic gate_n,
    output logic wake_pulse,
    output logic held_active,
    output logic release_pulse,
    output logic cfg_abort
);
    logic cls_cfg_q, cls_wake_q, wake_q, rel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_cfg_q  <= 1'b0;
            cls_wake_q <= 1'b0;
            wake_q     <= 1'b0;
            rel_q      <= 1'b0;
        end else begin
            wake_q <= 1'b0;
            rel_q  <= ev_release && cls_wake_q;
            if (ev_start) begin
                cls_cfg_q  <= cfg_busy;
                cls_wake_q <= 1'b0;
            end
            if (ev_valid) begin
                cls_wake_q <= !cls_cfg_q && gate_n;
                wake_q     <= !cls_cfg_q && gate_n;
            end
        end
    end

    always_comb begin
        wake_pulse    = wake_q;
        release_pulse = rel_q;
        held_active   = latched && cls_wake_q;
        cfg_abort     = in_press && cls_cfg_q;
    end

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R3
    AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> held_active); // R5
    AST_WAKE_POWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(gate_n)); // R7
    AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |-> !held_active); // R6
    AST_ABORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_abort |-> (!held_active && !wake_pulse && !release_pulse)); // R8
endmodule

// File: rtl/manual_wake_detector.sv
module manual_wake_detector #(
    parameter int SYNC_STAGES = 2,
    parameter int HIGH_MS     = 20,
    parameter int WINDOW_MS   = 30,
    parameter int LOW_MS      = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic btn_raw,
    input  logic cfg_busy,
    input  logic gate_n,
    output logic wake_pulse,
    output logic held_active,
    output logic release_pulse,
    output logic cfg_abort
);
    logic btn_s, ev_start, ev_valid, ev_release, in_press, latched;

    mwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(btn_raw), .dout(btn_s)
    );

    mwd_fsm #(.HIGH_MS(HIGH_MS), .WINDOW_MS(WINDOW_MS), .LOW_MS(LOW_MS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick_ms), .sample(btn_s),
        .ev_start(ev_start), .ev_valid(ev_valid), .ev_release(ev_release),
        .in_press(in_press), .latched(latched)
    );

    mwd_class u_class (
        .clk(clk), .rst_n(rst_n),
        .ev_start(ev_start), .ev_valid(ev_valid), .ev_release(ev_release),
        .in_press(in_press), .latched(latched),
        .cfg_busy(cfg_busy), .gate_n(gate_n),
        .wake_pulse(wake_pulse), .held_active(held_active),
        .release_pulse(release_pulse), .cfg_abort(cfg_abort)
    );
endmodule

// File: tb/test_manual_wake_detector.sv
module test_manual_wake_detector;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0, btn_raw = 1'b0, cfg_busy = 1'b0, gate_n = 1'b1;
    logic wake_pulse, held_active, release_pulse, cfg_abort;

    int checks = 0;
    int errors = 0;

    int m_st = 0, m_hi = 0, m_win = 0, m_lo = 0;
    bit m_cfg = 0, m_cw = 0, e_wake = 0, e_rel = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    manual_wake_detector i_manual_wake_detector (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn_raw(btn_raw),
        .cfg_busy(cfg_busy), .gate_n(gate_n), .wake_pulse(wake_pulse),
        .held_active(held_active), .release_pulse(release_pulse), .cfg_abort(cfg_abort)
    );

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Tick-level reference built from R3..R8
    task automatic model_tick(bit b, bit busy, bit gate);
        e_wake = 0; e_rel = 0;
        case (m_st)
            0: if (b) begin m_st = 1; m_hi = 1; m_win = 1; m_cfg = busy; m_cw = 0; end
            1: begin
                m_win++; m_hi += int'(b);
                if (m_hi == 20) begin m_st = 2; m_cw = !m_cfg && gate; e_wake = m_cw; end
                else if (m_win == 30) m_st = 0;
            end
            2: if (!b) begin m_st = 3; m_lo = 1; end
            default: if (b) m_st = 2;
                     else begin m_lo++; if (m_lo == 20) begin m_st = 0; e_rel = m_cw; end end
        endcase
    endtask

    task automatic step(bit b, bit busy, bit gate, string tag);
        btn_raw = b; cfg_busy = busy; gate_n = gate;
        @(negedge clk);
        check({tag, " R3 wake lasts one cycle"}, wake_pulse, 1'b0);
        check({tag, " R6 release lasts one cycle"}, release_pulse, 1'b0);
        @(negedge clk);
        @(negedge clk);
        tick_ms = 1'b1;
        @(negedge clk);
        tick_ms = 1'b0;
        model_tick(b, busy, gate);
        check({tag, " R3 wake_pulse"}, wake_pulse, e_wake);
        check({tag, " R6 release_pulse"}, release_pulse, e_rel);
        check({tag, " R5 held_active"}, held_active, m_cw && (m_st == 2 || m_st == 3));
        check({tag, " R8 cfg_abort"}, cfg_abort, m_cfg && (m_st != 0));
    endtask

    task automatic run(bit b, int n, bit busy, bit gate, string tag);
        for (int i = 0; i < n; i++) step(b, busy, gate, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1357;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        check("R1 reset wake", wake_pulse, 1'b0);
        check("R1 reset held", held_active, 1'b0);
        check("R1 reset release", release_pulse, 1'b0);
        check("R1 reset abort", cfg_abort, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset held", held_active, 1'b0);

        // R2: high level between ticks only
        btn_raw = 1'b1; @(negedge clk); btn_raw = 1'b0;
        run(0, 2, 0, 1, "R2 glitch between ticks");

        run(1, 19, 0, 1, "R4 19 highs");
        run(0, 15, 0, 1, "R4 reject tail");
        run(1, 20, 0, 1, "R3 exact 20");
        run(1, 5, 0, 1, "R5 hold");
        run(0, 19, 0, 1, "R5 19 lows");
        run(1, 3, 0, 1, "R5 bounce back");
        run(0, 20, 0, 1, "R6 release");
        for (int k = 0; k < 10; k++) begin
            run(1, 2, 0, 1, "R3 gapped");
            run(0, 1, 0, 1, "R3 gapped");
        end
        run(0, 25, 0, 1, "R6 release gapped");
        run(1, 22, 0, 0, "R7 power on");
        run(0, 22, 0, 0, "R7 release ignored");
        run(1, 24, 1, 1, "R8 cfg press");
        run(0, 22, 0, 1, "R8 cfg release");
        run(1, 10, 1, 1, "R8 cfg short");
        run(0, 25, 0, 1, "R4 cfg short reject");

        for (int r = 0; r < 300; r++) begin
            bit busy, gate;
            int len;
            busy = ($urandom % 6) == 0;
            gate = ($urandom % 4) != 0;
            len = 1 + int'($urandom % 26);
            run(1, len, busy, gate, "rand high");
            len = 1 + int'($urandom % 26);
            run(0, len, busy, gate, "rand low");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule